// File: doc/BRIEF.md
# Multi-Chip Segment Address Decoder

This block sits in front of a group of flash chip selects and maps one shared memory-bus address space onto them. For each chip select it keeps a segment register that holds the lower and upper bound of that chip's address window. Both bounds are coarse 8 MB units. A lookup presents a bus address. One cycle later the block returns which chip select owns that address and the byte offset inside that chip's window. If no chip owns the address, it returns a decode error.

Software lays the windows out back to back across the chip selects and reads each register back to confirm that the write took effect. A window whose lower bound is not below its upper bound is closed and claims no addresses. A write that would push a window's upper bound past the total decode window is refused. Chip-select count and window size are parameters. The defaults are three chip selects and a 256 MB window.

Top module: `seg_decoder`

## Requirements
- R1: After reset, every segment register reads zero, so every window is closed. `dec_valid` stays low until a lookup is made.
- R2: Segment register n sits at byte address REG_BASE + 4*n (default 0x30). Its upper bound is in bits [31:24] and its lower bound in bits [23:16], both counted in 8 MB units. Bits [15:0] always read back as zero, whatever was written to them.
- R3: A write whose upper-bound field exceeds WIN_MB/8 (32 by default) is refused, and the register keeps its previous value.
- R4: A segment whose lower bound is greater than or equal to its upper bound decodes no address.
- R5: An address hits chip n when lower_n <= addr/8MB < upper_n. On a hit, `dec_sel` is one-hot with bit n set, `dec_idx` equals n and `dec_err` is low.
- R6: When several open segments contain the address, the lowest-numbered chip select wins.
- R7: An address that no open segment contains gives `dec_err` high, `dec_sel` all zero, `dec_idx` zero and `dec_offset` zero.
- R8: On a hit, `dec_offset` equals the address minus lower_n * 8 MB.
- R9: `dec_valid` is high in exactly the cycle after a cycle with `lk_valid` high, and low in every other cycle.
- R10: A register read at an address that holds no segment register returns zero. A write to such an address changes no segment register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on the next cycle |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, updated one cycle after reg_rd |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Bus address to decode |
| dec_valid | output | 1 | Decode result valid |
| dec_sel | output | NUM_CS | One-hot chip select |
| dec_idx | output | IDX_W | Index of the selected chip |
| dec_offset | output | ADDR_W | Offset inside the selected window |
| dec_err | output | 1 | No open segment contains the address |

## Verification
The bench probes addresses at the first and last byte of each window. A comparator with an off-by-one bound there would hand the last 8 MB to the next chip, or would claim the first unit of a neighbour. It builds overlapping windows to show that priority goes to the lowest chip select, not the highest, and closes a window with equal bounds to catch a `<=` upper-bound test. It writes upper bounds just past the window limit to catch a refused write that corrupts the register or that stores anyway. It also writes to addresses beyond the last register to catch aliasing of out-of-range writes onto a real segment.

// File: rtl/seg_pkg.sv
package seg_pkg;
  // one 8 MB unit
  localparam int UNIT_SHIFT = 23;

  typedef struct packed {
    logic [7:0] hi;  // exclusive upper bound, 8 MB units
    logic [7:0] lo;  // inclusive lower bound, 8 MB units
  } seg_bounds_t;

  function automatic logic [31:0] seg_to_word(input seg_bounds_t b);
    return {b.hi, b.lo, 16'h0000};
  endfunction
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_pkg::*;
#(
  parameter int         NUM_CS    = 3,
  parameter int         WIN_UNITS = 32,
  parameter logic [7:0] REG_BASE  = 8'h30
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr,
  input  logic                     rd,
  input  logic [7:0]               addr,
  input  logic [31:0]              wdata,
  output logic [31:0]              rdata,
  output seg_bounds_t [NUM_CS-1:0] bounds
);
  localparam logic [7:0] LIMIT = 8'(WIN_UNITS);

  logic [NUM_CS-1:0] slot_hit;
  logic              hi_ok;

  assign hi_ok = (wdata[31:24] <= LIMIT);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_slot
    localparam logic [7:0] SLOT_ADDR = 8'(int'(REG_BASE) + 4 * i);
    assign slot_hit[i] = (addr == SLOT_ADDR);

    always_ff @(posedge clk) begin
      if (rst) begin
        bounds[i] <= '0;
      end else if (wr && slot_hit[i] && hi_ok) begin
        bounds[i].hi <= wdata[31:24];
        bounds[i].lo <= wdata[23:16];
      end
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (slot_hit[i]) rd_mux = seg_to_word(bounds[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/seg_match.sv
module seg_match
  import seg_pkg::*;
#(
  parameter int NUM_CS = 3,
  parameter int ADDR_W = 28
) (
  input  seg_bounds_t [NUM_CS-1:0] bounds,
  input  logic [ADDR_W-1:0]        addr,
  output logic [NUM_CS-1:0]        hit
);
  localparam int UW = ADDR_W - UNIT_SHIFT;

  logic [7:0] unit;
  assign unit = 8'(addr[ADDR_W-1:UNIT_SHIFT]);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cmp
    // a closed window (lo >= hi) can never satisfy both compares
    assign hit[i] = (unit >= bounds[i].lo) && (unit < bounds[i].hi);
  end

  if (UW > 8) begin : g_bad_width
    initial $error("seg_match: ADDR_W too wide for 8-bit unit fields");
  end
endmodule

// File: rtl/seg_prio.sv
module seg_prio #(
  parameter int NUM_CS = 3,
  parameter int IDX_W  = 2
) (
  input  logic [NUM_CS-1:0] req,
  output logic [NUM_CS-1:0] gnt,
  output logic [IDX_W-1:0]  idx,
  output logic              any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IDX_W'(i);
      end
    end
  end
  assign any = |req;
endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
  import seg_pkg::*;
#(
  parameter int         NUM_CS   = 3,
  parameter int         WIN_MB   = 256,
  parameter logic [7:0] REG_BASE = 8'h30,
  parameter int         ADDR_W   = $clog2(WIN_MB) + 20,
  parameter int         IDX_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              dec_valid,
  output logic [NUM_CS-1:0] dec_sel,
  output logic [IDX_W-1:0]  dec_idx,
  output logic [ADDR_W-1:0] dec_offset,
  output logic              dec_err
);
  localparam int WIN_UNITS = WIN_MB / 8;

  seg_bounds_t [NUM_CS-1:0] bounds;
  logic [NUM_CS-1:0]        hit;
  logic [NUM_CS-1:0]        gnt;
  logic [IDX_W-1:0]         idx;
  logic                     any;

  seg_regfile #(
    .NUM_CS   (NUM_CS),
    .WIN_UNITS(WIN_UNITS),
    .REG_BASE (REG_BASE)
  ) u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr    (reg_wr),
    .rd    (reg_rd),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .bounds(bounds)
  );

  seg_match #(
    .NUM_CS(NUM_CS),
    .ADDR_W(ADDR_W)
  ) u_match (
    .bounds(bounds),
    .addr  (lk_addr),
    .hit   (hit)
  );

  seg_prio #(
    .NUM_CS(NUM_CS),
    .IDX_W (IDX_W)
  ) u_prio (
    .req(hit),
    .gnt(gnt),
    .idx(idx),
    .any(any)
  );

  // lower bound of the winning window, as a byte address
  logic [31:0] win_base;
  logic [31:0] off_full;
  always_comb begin
    win_base = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (gnt[i]) win_base = 32'(bounds[i].lo) << UNIT_SHIFT;
    end
    off_full = 32'(lk_addr) - win_base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_sel    <= '0;
      dec_idx    <= '0;
      dec_offset <= '0;
      dec_err    <= 1'b0;
    end else begin
      dec_valid <= lk_valid;
      if (lk_valid) begin
        dec_sel    <= gnt;
        dec_idx    <= idx;
        dec_offset <= any ? off_full[ADDR_W-1:0] : '0;
        dec_err    <= ~any;
      end
    end
  end
endmodule

// File: rtl/seg_decoder_chk.sv
module seg_decoder_chk #(
  parameter int NUM_CS = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic              dec_valid,
  input logic [NUM_CS-1:0] dec_sel,
  input logic              dec_err,
  input logic [31:0]       reg_rdata
);
  p_sel_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $onehot0(dec_sel));

  p_hit_xor_err_r5: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (dec_err != (dec_sel != '0)));

  p_miss_nosel_r7: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_err) |-> (dec_sel == '0));

  p_valid_follows_r9: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> dec_valid);

  p_valid_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !dec_valid);

  p_low_zero_r2: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[15:0] == 16'h0000);
endmodule

bind seg_decoder seg_decoder_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .lk_valid (lk_valid),
  .dec_valid(dec_valid),
  .dec_sel  (dec_sel),
  .dec_err  (dec_err),
  .reg_rdata(reg_rdata)
);

// File: tb/tb_seg_decoder.sv
`timescale 1ns/1ps
module tb_seg_decoder;
  localparam int NUM_CS = 3;
  localparam int WIN_MB = 256;
  localparam int ADDR_W = 28;
  localparam int IDX_W  = 2;
  localparam int LIMIT  = WIN_MB / 8;
  localparam logic [7:0] BASE = 8'h30;

  logic              clk = 0;
  logic              rst = 1;
  logic              reg_wr = 0, reg_rd = 0;
  logic [7:0]        reg_addr = 0;
  logic [31:0]       reg_wdata = 0;
  logic [31:0]       reg_rdata;
  logic              lk_valid = 0;
  logic [ADDR_W-1:0] lk_addr = 0;
  logic              dec_valid;
  logic [NUM_CS-1:0] dec_sel;
  logic [IDX_W-1:0]  dec_idx;
  logic [ADDR_W-1:0] dec_offset;
  logic              dec_err;

  always #2 clk = ~clk;

  seg_decoder #(.NUM_CS(NUM_CS), .WIN_MB(WIN_MB)) dut (.*);

  int errors = 0, checks = 0;
  bit done = 0;
  int m_lo [NUM_CS];
  int m_hi [NUM_CS];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    if (a >= BASE && a[1:0] == 0 && (a - BASE) / 4 < NUM_CS && d[31:24] <= LIMIT) begin
      m_hi[(a - BASE) / 4] = d[31:24];
      m_lo[(a - BASE) / 4] = d[23:16];
    end
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] exp_word(input logic [7:0] a);
    if (a >= BASE && a[1:0] == 0 && (a - BASE) / 4 < NUM_CS)
      return {8'(m_hi[(a - BASE) / 4]), 8'(m_lo[(a - BASE) / 4]), 16'h0};
    return 32'h0;
  endfunction

  task automatic check_reg(input logic [7:0] a, input string tag);
    logic [31:0] d;
    rd_reg(a, d);
    chk(d == exp_word(a), tag, d, exp_word(a));
  endtask

  task automatic lookup(input logic [ADDR_W-1:0] a, input string tag);
    int u, w;
    logic [ADDR_W-1:0] eoff;
    @(negedge clk);
    lk_valid = 1; lk_addr = a;
    @(negedge clk);
    lk_valid = 0;
    u = int'(a >> 23);
    w = -1;
    for (int i = NUM_CS - 1; i >= 0; i--)
      if (m_lo[i] < m_hi[i] && u >= m_lo[i] && u < m_hi[i]) w = i;
    chk(dec_valid == 1, {tag, " R9 valid"}, dec_valid, 1);
    if (w < 0) begin
      chk(dec_err == 1 && dec_sel == 0 && dec_idx == 0 && dec_offset == 0,
          {tag, " R7 miss"}, {dec_err, dec_sel, dec_offset}, {1'b1, 3'b0, 28'h0});
    end else begin
      eoff = a - ADDR_W'(m_lo[w] << 23);
      chk(dec_err == 0 && dec_sel == (NUM_CS'(1) << w) && dec_idx == IDX_W'(w),
          {tag, " R5 R6 select"}, {dec_err, dec_sel}, {1'b0, NUM_CS'(NUM_CS'(1) << w)});
      chk(dec_offset == eoff, {tag, " R8 offset"}, dec_offset, eoff);
    end
  endtask

  initial begin
    logic [31:0] d;
    for (int i = 0; i < NUM_CS; i++) begin m_lo[i] = 0; m_hi[i] = 0; end
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(dec_valid == 0, "R1 idle after reset", dec_valid, 0);
    for (int i = 0; i < NUM_CS; i++) check_reg(BASE + 8'(4 * i), "R1 reset value");
    lookup(28'h0, "R1 closed after reset");

    // contiguous layout with junk in the low bits
    wr_reg(BASE + 0, {8'd4, 8'd0, 16'hBEEF});
    wr_reg(BASE + 4, {8'd12, 8'd4, 16'h1234});
    wr_reg(BASE + 8, {8'd32, 8'd12, 16'hFFFF});
    for (int i = 0; i < NUM_CS; i++) check_reg(BASE + 8'(4 * i), "R2 layout readback");
    lookup(28'h0, "R5 first byte cs0");
    lookup(28'h1FF_FFFF, "R5 last byte cs0");
    lookup(28'h200_0000, "R5 first byte cs1");
    lookup(28'h5FF_FFFF, "R5 last byte cs1");
    lookup(28'hFFF_FFFF, "R8 top of window");
    @(negedge clk);
    chk(dec_valid == 0, "R9 valid drops", dec_valid, 0);

    // refused writes
    wr_reg(BASE + 8, {8'd33, 8'd1, 16'h0});
    check_reg(BASE + 8, "R3 refused write keeps value");
    wr_reg(BASE + 8, {8'd255, 8'd0, 16'h0});
    check_reg(BASE + 8, "R3 refused write 255");
    wr_reg(BASE + 4, {8'd32, 8'd20, 16'h0});
    check_reg(BASE + 4, "R3 limit itself accepted");

    // closed window: equal bounds
    wr_reg(BASE + 4, {8'd5, 8'd5, 16'h0});
    lookup(28'h280_0000, "R4 equal bounds closed");
    wr_reg(BASE + 4, {8'd3, 8'd9, 16'h0});
    lookup(28'h300_0000, "R4 inverted bounds closed");

    // overlap
    wr_reg(BASE + 0, {8'd10, 8'd0, 16'h0});
    wr_reg(BASE + 4, {8'd10, 8'd2, 16'h0});
    lookup(28'h180_1234, "R6 overlap low cs wins");
    wr_reg(BASE + 0, {8'd1, 8'd0, 16'h0});
    lookup(28'h180_1234, "R6 cs1 after cs0 shrinks");

    // out-of-range register addresses
    wr_reg(BASE + 8'(4 * NUM_CS), 32'h0808_0000);
    wr_reg(BASE + 1, 32'h0707_0000);
    for (int i = 0; i < NUM_CS; i++) check_reg(BASE + 8'(4 * i), "R10 stray write no effect");
    check_reg(BASE + 8'(4 * NUM_CS), "R10 stray read zero");
    check_reg(8'h00, "R10 stray read zero low");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int k = $urandom % 10;
      if (k < 3) begin
        wr_reg(BASE + 8'(4 * ($urandom % (NUM_CS + 1))),
               {8'($urandom % 40), 8'($urandom % 34), 16'($urandom)});
      end else if (k < 4) begin
        check_reg(BASE + 8'(4 * ($urandom % (NUM_CS + 1))), "R2 random readback");
      end else begin
        int u = $urandom % 32;
        logic [22:0] o = ($urandom % 3 == 0) ? 23'h0 :
                         (($urandom % 2 == 0) ? 23'h7F_FFFF : 23'($urandom));
        lookup({u[4:0], o}, "R5 random lookup");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule